// File: doc/BRIEF.md
# USB PHY Power-Up and Reset Sequencer

This block brings a combined USB 2.0 / USB 3.x PHY and its host/device controller out of reset in a fixed order. On an init request it asserts all four reset lines. It then chooses the reference clock source and takes the USB2 PHY out of its quiescent-current mode and the USB3 PHY out of test power-down. After that it releases the PHY resets, waits, and reports analog power as stable. Spread-spectrum clocking is switched on next, then the controller and auxiliary resets are released. After a further wait it forces the VBUS-valid indications and hands the last step, programming of the PHY's tuning registers, to an external register-access engine through a request/acknowledge pair.

Every wait is timed by a counter: `WAIT_US` microseconds at `CLKS_PER_US` system clocks per microsecond, written WAIT_CYC below. An exit request from the ready state re-asserts only the two PHY resets and then turns off the clock enable that belongs to the clock source chosen at init. A failed programming step leaves the block latched in an error state until reset. The asynchronous reset input is released through an internal two-stage synchronizer, so the block starts to act two clocks after `rst_n` rises.

Top module: `usb_phy_pwrseq`

## Requirements
- R1: Out of reset, all four reset outputs are 0 (active), `u2_iddq` and `u3_test_pd` are 1, and every other output is 0.
- R2: An `init_req` sampled high while idle drives `aux_rst_n`, `ctrl_rst_n`, `u3phy_rst_n` and `u2phy_por_n` to 0, visible two clocks after the sampling edge.
- R3: One clock later the reference clock is set up. With `clk_src_pad`=0 it gives `{refclk_pad_sel,int_osc_en,pad_gate_en}`=3'b010, and with `clk_src_pad`=1 it gives 3'b101. The internal oscillator enable and the pad gate are never both 1.
- R4: `u2_iddq` falls one clock after the clock set-up, and `u3_test_pd` falls one clock after that. One clock later `u3phy_rst_n` and `u2phy_por_n` rise together, while the controller resets stay asserted.
- R5: `ana_pwr_en`, `pcs_pwr_stable` and `pma_pwr_stable` rise together exactly WAIT_CYC+1 clocks after the PHY reset release.
- R6: `ssc_en` rises 2 clocks after the power flags. `aux_rst_n` and `ctrl_rst_n` rise together 1 clock after `ssc_en`.
- R7: WAIT_CYC+1 clocks after the controller release, `vbus_ovr_val` and `vbus_ovr_sel` both become 2'b11 (bit 1 is USB3, bit 0 is USB2). `prog_req` rises WAIT_CYC clocks after that.
- R8: While `prog_req` is high, an edge that samples `prog_ack`=1 and `prog_err`=0 drops `prog_req` and raises `ready` at that edge. Without acknowledge, `prog_req` stays high.
- R9: An edge that samples `prog_err`=1 while `prog_req` is high raises `err`, even if `prog_ack` is also high. `err` then stays 1, `ready` stays 0, and `init_req` and `exit_req` have no effect until reset.
- R10: `init_req` is ignored whenever the block is not idle. Outputs are not re-asserted and the sequence timing does not change.
- R11: An `exit_req` sampled while ready drops `ready` at that edge. Two clocks after that edge both PHY resets are 0 while the controller resets stay 1. Three clocks after it, the clock enable of the source chosen at init is 0, and the block is idle again.
- R12: `exit_req` outside the ready state has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_req | input | 1 | Start the power-up sequence (accepted only while idle) |
| exit_req | input | 1 | Start the shutdown steps (accepted only while ready) |
| clk_src_pad | input | 1 | Reference clock source: 0 internal oscillator, 1 external pad |
| prog_ack | input | 1 | Parameter programming finished successfully |
| prog_err | input | 1 | Parameter programming failed |
| prog_req | output | 1 | Request to the register-access engine to program PHY parameters |
| ready | output | 1 | Sequence complete, PHY and controller usable |
| err | output | 1 | Sticky programming failure |
| aux_rst_n | output | 1 | Auxiliary-domain reset, active low |
| ctrl_rst_n | output | 1 | Controller reset, active low |
| u3phy_rst_n | output | 1 | USB3 PHY reset, active low |
| u2phy_por_n | output | 1 | USB2 PHY power-on reset, active low |
| u2_iddq | output | 1 | USB2 PHY quiescent-current (low-power) mode |
| u3_test_pd | output | 1 | USB3 PHY test power-down |
| ana_pwr_en | output | 1 | PHY analog power enable |
| pcs_pwr_stable | output | 1 | PCS power-stable indication |
| pma_pwr_stable | output | 1 | PMA power-stable indication |
| ssc_en | output | 1 | Spread-spectrum clocking enable |
| vbus_ovr_val | output | 2 | Forced VBUS-valid value, bit 1 USB3, bit 0 USB2 |
| vbus_ovr_sel | output | 2 | Selects the forced VBUS-valid value, bit 1 USB3, bit 0 USB2 |
| refclk_pad_sel | output | 1 | Reference clock mux: 1 pad, 0 internal |
| int_osc_en | output | 1 | Internal oscillator enable for the PHY reference |
| pad_gate_en | output | 1 | Pad reference clock gate enable |

## Verification
Every result has a fixed due cycle counted from the falling clock edge at which `init_req` is driven, with the bench configured for WAIT_CYC=6. The resets are due at +2, the clock set-up at +3, the quiescent and test power-down releases at +4 and +5, and the PHY release at +6. The power flags follow at +7+WAIT_CYC, SSC at +9+WAIT_CYC, the controller release at +10+WAIT_CYC, the VBUS overrides at +11+2·WAIT_CYC and the programming request at +11+3·WAIT_CYC. The bench steps one falling edge at a time and compares each output at its due cycle, and on the cycle just before it where the prior value is known. `ready`/`err` are compared one edge after the acknowledge, and the exit results at one, two and three edges after the exit request. Stray `init_req`/`exit_req` pulses are placed mid-sequence and their absence of effect is read at the ports two and three edges later.

// File: rtl/usb_pwrseq_pkg.sv
package usb_pwrseq_pkg;

  // Number of VBUS override lanes: index 1 is USB3, index 0 is USB2.
  parameter int unsigned VBUS_PORTS = 2;

  typedef enum logic [4:0] {
    S_IDLE,
    S_RST_ALL,
    S_REFCLK,
    S_IDDQ_OFF,
    S_TPD_OFF,
    S_PHY_REL,
    S_WAIT_PHY,
    S_PWR_GOOD,
    S_MODE_CFG,
    S_SSC_ON,
    S_CORE_REL,
    S_WAIT_CORE,
    S_VBUS_FORCE,
    S_WAIT_VBUS,
    S_PROG,
    S_READY,
    S_FAIL,
    S_EXIT_RST,
    S_EXIT_CLK
  } seq_state_e;

endpackage

// File: rtl/usb_pwrseq_rst_sync.sv
module usb_pwrseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/usb_pwrseq_timer.sv
module usb_pwrseq_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);

  localparam int unsigned CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? RELOAD : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == '0) && !load;

endmodule

// File: rtl/usb_pwrseq_fsm.sv
module usb_pwrseq_fsm
  import usb_pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       exit_req,
  input  logic       wait_done,
  input  logic       prog_ack,
  input  logic       prog_err,
  output seq_state_e state,
  output logic       wait_load,
  output logic       prog_req,
  output logic       ready,
  output logic       err
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:       if (init_req) state_d = S_RST_ALL;
      S_RST_ALL:    state_d = S_REFCLK;
      S_REFCLK:     state_d = S_IDDQ_OFF;
      S_IDDQ_OFF:   state_d = S_TPD_OFF;
      S_TPD_OFF:    state_d = S_PHY_REL;
      S_PHY_REL:    state_d = S_WAIT_PHY;
      S_WAIT_PHY:   if (wait_done) state_d = S_PWR_GOOD;
      S_PWR_GOOD:   state_d = S_MODE_CFG;
      S_MODE_CFG:   state_d = S_SSC_ON;
      S_SSC_ON:     state_d = S_CORE_REL;
      S_CORE_REL:   state_d = S_WAIT_CORE;
      S_WAIT_CORE:  if (wait_done) state_d = S_VBUS_FORCE;
      S_VBUS_FORCE: state_d = S_WAIT_VBUS;
      S_WAIT_VBUS:  if (wait_done) state_d = S_PROG;
      S_PROG: begin
        if (prog_err) begin
          state_d = S_FAIL;
        end else if (prog_ack) begin
          state_d = S_READY;
        end
      end
      S_READY:      if (exit_req) state_d = S_EXIT_RST;
      S_EXIT_RST:   state_d = S_EXIT_CLK;
      S_EXIT_CLK:   state_d = S_IDLE;
      S_FAIL:       state_d = S_FAIL;
      default:      state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state     = state_q;
  assign wait_load = (state_q == S_PHY_REL) || (state_q == S_CORE_REL) ||
                     (state_q == S_VBUS_FORCE);
  assign prog_req  = (state_q == S_PROG);
  assign ready     = (state_q == S_READY);
  assign err       = (state_q == S_FAIL);

endmodule

// File: rtl/usb_pwrseq_ctl.sv
module usb_pwrseq_ctl
  import usb_pwrseq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  seq_state_e            state,
  input  logic                  clk_src_pad,
  output logic                  aux_rst_n,
  output logic                  ctrl_rst_n,
  output logic                  u3phy_rst_n,
  output logic                  u2phy_por_n,
  output logic                  u2_iddq,
  output logic                  u3_test_pd,
  output logic                  ana_pwr_en,
  output logic                  pcs_pwr_stable,
  output logic                  pma_pwr_stable,
  output logic                  ssc_en,
  output logic [VBUS_PORTS-1:0] vbus_ovr_val,
  output logic [VBUS_PORTS-1:0] vbus_ovr_sel,
  output logic                  refclk_pad_sel,
  output logic                  int_osc_en,
  output logic                  pad_gate_en
);

  // Clock enables and next values, one group per control
  logic phy_rst_we, phy_rst_d;
  logic core_rst_we, core_rst_d;
  logic iddq_we, tpd_we, pwr_we, ssc_we, vbus_we;
  logic refclk_we, clkoff_we;
  logic src_q;

  always_comb begin
    phy_rst_we  = (state == S_RST_ALL) || (state == S_PHY_REL) || (state == S_EXIT_RST);
    phy_rst_d   = (state == S_PHY_REL);
    core_rst_we = (state == S_RST_ALL) || (state == S_CORE_REL);
    core_rst_d  = (state == S_CORE_REL);
    iddq_we     = (state == S_IDDQ_OFF);
    tpd_we      = (state == S_TPD_OFF);
    pwr_we      = (state == S_PWR_GOOD);
    ssc_we      = (state == S_SSC_ON);
    vbus_we     = (state == S_VBUS_FORCE);
    refclk_we   = (state == S_REFCLK);
    clkoff_we   = (state == S_EXIT_CLK);
  end

  // PHY resets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u3phy_rst_n <= 1'b0;
      u2phy_por_n <= 1'b0;
    end else if (phy_rst_we) begin
      u3phy_rst_n <= phy_rst_d;
      u2phy_por_n <= phy_rst_d;
    end
  end

  // Controller-side resets
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aux_rst_n  <= 1'b0;
      ctrl_rst_n <= 1'b0;
    end else if (core_rst_we) begin
      aux_rst_n  <= core_rst_d;
      ctrl_rst_n <= core_rst_d;
    end
  end

  // Low-power controls
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u2_iddq <= 1'b1;
    end else if (iddq_we) begin
      u2_iddq <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      u3_test_pd <= 1'b1;
    end else if (tpd_we) begin
      u3_test_pd <= 1'b0;
    end
  end

  // Power-stable flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ana_pwr_en     <= 1'b0;
      pcs_pwr_stable <= 1'b0;
      pma_pwr_stable <= 1'b0;
    end else if (pwr_we) begin
      ana_pwr_en     <= 1'b1;
      pcs_pwr_stable <= 1'b1;
      pma_pwr_stable <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ssc_en <= 1'b0;
    end else if (ssc_we) begin
      ssc_en <= 1'b1;
    end
  end

  // VBUS-valid overrides, one value/select pair per lane
  for (genvar g = 0; g < VBUS_PORTS; g++) begin : g_vbus
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vbus_ovr_val[g] <= 1'b0;
        vbus_ovr_sel[g] <= 1'b0;
      end else if (vbus_we) begin
        vbus_ovr_val[g] <= 1'b1;
        vbus_ovr_sel[g] <= 1'b1;
      end
    end
  end

  // Reference clock selection, remembered for the shutdown steps
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q          <= 1'b0;
      refclk_pad_sel <= 1'b0;
    end else if (refclk_we) begin
      src_q          <= clk_src_pad;
      refclk_pad_sel <= clk_src_pad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_osc_en <= 1'b0;
    end else if (refclk_we) begin
      int_osc_en <= !clk_src_pad;
    end else if (clkoff_we && !src_q) begin
      int_osc_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_gate_en <= 1'b0;
    end else if (refclk_we) begin
      pad_gate_en <= clk_src_pad;
    end else if (clkoff_we && src_q) begin
      pad_gate_en <= 1'b0;
    end
  end

endmodule

// File: rtl/usb_phy_pwrseq.sv
module usb_phy_pwrseq
  import usb_pwrseq_pkg::*;
#(
  parameter int unsigned CLKS_PER_US = 10,
  parameter int unsigned WAIT_US     = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       init_req,
  input  logic       exit_req,
  input  logic       clk_src_pad,
  input  logic       prog_ack,
  input  logic       prog_err,
  output logic       prog_req,
  output logic       ready,
  output logic       err,
  output logic       aux_rst_n,
  output logic       ctrl_rst_n,
  output logic       u3phy_rst_n,
  output logic       u2phy_por_n,
  output logic       u2_iddq,
  output logic       u3_test_pd,
  output logic       ana_pwr_en,
  output logic       pcs_pwr_stable,
  output logic       pma_pwr_stable,
  output logic       ssc_en,
  output logic [1:0] vbus_ovr_val,
  output logic [1:0] vbus_ovr_sel,
  output logic       refclk_pad_sel,
  output logic       int_osc_en,
  output logic       pad_gate_en
);

  localparam int unsigned WAIT_CYC = CLKS_PER_US * WAIT_US;

  logic       rst_n_sync;
  logic       wait_load;
  logic       wait_done;
  seq_state_e state;

  usb_pwrseq_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  usb_pwrseq_timer #(.CYCLES(WAIT_CYC)) timer_i (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (wait_load),
    .done  (wait_done)
  );

  usb_pwrseq_fsm fsm_i (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .init_req  (init_req),
    .exit_req  (exit_req),
    .wait_done (wait_done),
    .prog_ack  (prog_ack),
    .prog_err  (prog_err),
    .state     (state),
    .wait_load (wait_load),
    .prog_req  (prog_req),
    .ready     (ready),
    .err       (err)
  );

  usb_pwrseq_ctl ctl_i (
    .clk            (clk),
    .rst_n          (rst_n_sync),
    .state          (state),
    .clk_src_pad    (clk_src_pad),
    .aux_rst_n      (aux_rst_n),
    .ctrl_rst_n     (ctrl_rst_n),
    .u3phy_rst_n    (u3phy_rst_n),
    .u2phy_por_n    (u2phy_por_n),
    .u2_iddq        (u2_iddq),
    .u3_test_pd     (u3_test_pd),
    .ana_pwr_en     (ana_pwr_en),
    .pcs_pwr_stable (pcs_pwr_stable),
    .pma_pwr_stable (pma_pwr_stable),
    .ssc_en         (ssc_en),
    .vbus_ovr_val   (vbus_ovr_val),
    .vbus_ovr_sel   (vbus_ovr_sel),
    .refclk_pad_sel (refclk_pad_sel),
    .int_osc_en     (int_osc_en),
    .pad_gate_en    (pad_gate_en)
  );

endmodule

// File: rtl/usb_phy_pwrseq_chk.sv
module usb_phy_pwrseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       init_req,
  input logic       exit_req,
  input logic       clk_src_pad,
  input logic       prog_ack,
  input logic       prog_err,
  input logic       prog_req,
  input logic       ready,
  input logic       err,
  input logic       aux_rst_n,
  input logic       ctrl_rst_n,
  input logic       u3phy_rst_n,
  input logic       u2phy_por_n,
  input logic       u2_iddq,
  input logic       u3_test_pd,
  input logic       ana_pwr_en,
  input logic       pcs_pwr_stable,
  input logic       pma_pwr_stable,
  input logic       ssc_en,
  input logic [1:0] vbus_ovr_val,
  input logic [1:0] vbus_ovr_sel,
  input logic       refclk_pad_sel,
  input logic       int_osc_en,
  input logic       pad_gate_en
);

  AST_REFCLK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_osc_en && pad_gate_en)); // R3

  AST_PWR_AFTER_PHY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcs_pwr_stable) |-> (u3phy_rst_n && u2phy_por_n && !ctrl_rst_n)); // R5

  AST_CORE_AFTER_SSC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rst_n) |-> (ssc_en && pma_pwr_stable && aux_rst_n)); // R6

  AST_VBUS_AFTER_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vbus_ovr_val[0]) |-> (ctrl_rst_n && aux_rst_n)); // R7

  AST_READY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(prog_req && prog_ack && !prog_err)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !ready)); // R9

  AST_EXIT_PHY_RST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |=> (!u3phy_rst_n && !u2phy_por_n && ctrl_rst_n)); // R11

endmodule

bind usb_phy_pwrseq usb_phy_pwrseq_chk chk_i (.*);

// File: tb/usb_phy_pwrseq_tb_top.sv
module usb_phy_pwrseq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CPU = 3;
  localparam int WUS = 2;
  localparam int W   = CPU * WUS;

  logic       clk = 1'b0;
  logic       rst_n, init_req, exit_req, clk_src_pad, prog_ack, prog_err;
  logic       prog_req, ready, err;
  logic       aux_rst_n, ctrl_rst_n, u3phy_rst_n, u2phy_por_n;
  logic       u2_iddq, u3_test_pd, ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, ssc_en;
  logic [1:0] vbus_ovr_val, vbus_ovr_sel;
  logic       refclk_pad_sel, int_osc_en, pad_gate_en;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_phy_pwrseq #(.CLKS_PER_US(CPU), .WAIT_US(WUS)) dut_i (.*);

  // Due cycles, counted in falling edges from the one that drives init_req
  function automatic int due_rst();  return 2;           endfunction
  function automatic int due_clk();  return 3;           endfunction
  function automatic int due_iddq(); return 4;           endfunction
  function automatic int due_tpd();  return 5;           endfunction
  function automatic int due_phy();  return 6;           endfunction
  function automatic int due_pwr();  return 7 + W;       endfunction
  function automatic int due_ssc();  return 9 + W;       endfunction
  function automatic int due_core(); return 10 + W;      endfunction
  function automatic int due_vbus(); return 11 + 2 * W;  endfunction
  function automatic int due_req();  return 11 + 3 * W;  endfunction
  function automatic int clk_cfg(bit src); return src ? 3'b101 : 3'b010; endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; init_req = 1'b0; exit_req = 1'b0;
    prog_ack = 1'b0; prog_err = 1'b0; clk_src_pad = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic chk_reset_state();
    chk("R1 resets", int'({aux_rst_n, ctrl_rst_n, u3phy_rst_n, u2phy_por_n}), 0);
    chk("R1 iddq/tpd", int'({u2_iddq, u3_test_pd}), 3);
    chk("R1 power/ssc", int'({ana_pwr_en, pcs_pwr_stable, pma_pwr_stable, ssc_en}), 0);
    chk("R1 vbus", int'({vbus_ovr_val, vbus_ovr_sel}), 0);
    chk("R1 clocks", int'({refclk_pad_sel, int_osc_en, pad_gate_en}), 0);
    chk("R1 status", int'({prog_req, ready, err}), 0);
  endtask

  // Runs the sequence up to the programming request. fresh: previous values known from reset.
  task automatic run_seq(bit src, bit fresh, int noise_k, int xnoise_k);
    init_req = 1'b1;
    clk_src_pad = src;
    for (int k = 1; k <= due_req(); k++) begin
      step();
      init_req = (k == noise_k);
      exit_req = (k == xnoise_k);
      if (k == due_rst())
        chk("R2 all resets asserted", int'({aux_rst_n, ctrl_rst_n, u3phy_rst_n, u2phy_por_n}), 0);
      if (fresh && k == due_clk() - 1)
        chk("R3 clock not yet set", int'({refclk_pad_sel, int_osc_en, pad_gate_en}), 0);
      if (k == due_clk())
        chk("R3 clock setup", int'({refclk_pad_sel, int_osc_en, pad_gate_en}), clk_cfg(src));
      if (fresh && k == due_iddq())
        chk("R4 iddq off, tpd on", int'({u2_iddq, u3_test_pd}), 1);
      if (k == due_tpd())
        chk("R4 tpd off, phy held", int'({u3_test_pd, u3phy_rst_n, u2phy_por_n}), 0);
      if (k == due_phy())
        chk("R4 phy released, core held", int'({u3phy_rst_n, u2phy_por_n, aux_rst_n, ctrl_rst_n}), 4'b1100);
      if (fresh && k == due_pwr() - 1)
        chk("R5 power early", int'({ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}), 0);
      if (k == due_pwr())
        chk("R5 power stable", int'({ana_pwr_en, pcs_pwr_stable, pma_pwr_stable}), 7);
      if (fresh && k == due_ssc() - 1)
        chk("R6 ssc early", int'(ssc_en), 0);
      if (k == due_ssc())
        chk("R6 ssc on, core held", int'({ssc_en, aux_rst_n, ctrl_rst_n}), 4);
      if (k == due_core())
        chk("R6 core released", int'({aux_rst_n, ctrl_rst_n}), 3);
      if (fresh && k == due_vbus() - 1)
        chk("R7 vbus early", int'({vbus_ovr_val, vbus_ovr_sel}), 0);
      if (k == due_vbus())
        chk("R7 vbus forced", int'({vbus_ovr_val, vbus_ovr_sel}), 15);
      if (k == due_req() - 1)
        chk("R7 prog_req early", int'(prog_req), 0);
      if (k == due_req())
        chk("R7 prog_req", int'(prog_req), 1);
      if (noise_k > 0 && k == noise_k + 2)
        chk("R10 init ignored", int'({u3phy_rst_n, aux_rst_n}),
            int'({k >= due_phy(), k >= due_core()}));
      if (xnoise_k > 0 && k == xnoise_k + 2)
        chk("R12 exit ignored phy", int'(u3phy_rst_n), int'(k >= due_phy()));
      if (xnoise_k > 0 && k == xnoise_k + 3)
        chk("R12 exit ignored clock", int'({refclk_pad_sel, int_osc_en, pad_gate_en}), clk_cfg(src));
    end
    init_req = 1'b0;
    exit_req = 1'b0;
  endtask

  task automatic finish_prog(int dly, bit fail, bit also_ack);
    for (int d = 0; d < dly; d++) begin
      step();
      chk("R8 holds request", int'({prog_req, ready}), 2);
    end
    prog_err = fail;
    prog_ack = !fail || also_ack;
    step();
    prog_ack = 1'b0;
    prog_err = 1'b0;
    if (fail) chk("R9 error raised", int'({err, ready, prog_req}), 4);
    else      chk("R8 ready on ack", int'({ready, prog_req, err}), 4);
  endtask

  task automatic chk_sticky();
    init_req = 1'b1; exit_req = 1'b1;
    step();
    init_req = 1'b0; exit_req = 1'b0;
    repeat (3) step();
    chk("R9 error sticky", int'({err, ready}), 2);
    chk("R9 outputs frozen", int'({u3phy_rst_n, u2phy_por_n, aux_rst_n, ctrl_rst_n}), 15);
  endtask

  task automatic do_exit(bit src);
    exit_req = 1'b1;
    step();
    exit_req = 1'b0;
    chk("R11 ready drops", int'({ready, u3phy_rst_n}), 1);
    step();
    chk("R11 phy resets asserted", int'({u3phy_rst_n, u2phy_por_n, aux_rst_n, ctrl_rst_n}), 3);
    step();
    chk("R11 clock disabled", int'({refclk_pad_sel, int_osc_en, pad_gate_en}), src ? 4 : 0);
  endtask

  initial begin
    automatic int unsigned seed = 32'd20240611;
    void'($urandom(seed));
    do_reset();
    chk_reset_state();
    chk("R12 exit while idle", int'(int_osc_en), 0);

    // Directed: internal clock, immediate ack, stray init in READY, exit, re-init on pad
    run_seq(1'b0, 1'b1, due_phy() + 2, due_pwr() + 1);
    finish_prog(0, 1'b0, 1'b0);
    init_req = 1'b1;
    step();
    init_req = 1'b0;
    step();
    chk("R10 init in ready ignored", int'({ready, ctrl_rst_n, u3phy_rst_n}), 7);
    do_exit(1'b0);
    run_seq(1'b1, 1'b0, 0, 0);
    finish_prog(2, 1'b0, 1'b0);
    do_exit(1'b1);

    // Directed: error and acknowledge together, error wins
    do_reset();
    run_seq(1'b1, 1'b1, 0, 0);
    finish_prog(1, 1'b1, 1'b1);
    chk_sticky();

    // Random runs
    for (int r = 0; r < 14; r++) begin
      automatic bit src  = 1'(($urandom() >> 3) & 1);
      automatic int dly  = int'($urandom() % 4);
      automatic bit fail = (($urandom() % 5) == 0);
      automatic int nk   = 2 + int'($urandom() % (due_req() - 3));
      automatic int xk   = 2 + int'($urandom() % (due_req() - 3));
      do_reset();
      run_seq(src, 1'b1, nk, xk);
      finish_prog(dly, fail, 1'(($urandom() >> 5) & 1));
      if (fail) chk_sticky();
      else      do_exit(src);
    end

    summary();
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
    $finish;
  end

endmodule